// File: doc/BRIEF.md
# Flag-Generating Byte/Word ALU

This block is a 16-bit integer arithmetic and logic unit with a byte/word width select. It computes add, add-with-carry, subtract, subtract-with-borrow, compare, increment, decrement and the bitwise AND, OR and XOR. It also executes three carry-flag control operations: set, clear and complement. Alongside the result it returns a complete 16-bit status word. This word contains carry, auxiliary carry, parity, zero, sign and overflow at fixed bit positions. Every other bit of the word is copied from the incoming status word.

The caller presents two operands, an opcode, the width select and the current status word on a valid strobe. One clock later the block returns the result, the updated status word and a write-enable. The write-enable tells the caller whether the result belongs in a destination register. Compare and the carry-flag operations never assert it. Carry-in for add-with-carry and subtract-with-borrow is taken from bit 0 of the incoming status word.

Top module: `flag_alu`

## Requirements
- R1: While rst_ni is low, valid_o, result_we_o, result_o and flags_o are all zero.
- R2: An operation presented with valid_i high in one cycle appears on the outputs, with valid_o high, after the next rising clock edge. With valid_i low, valid_o and result_we_o are 0 and result_o and flags_o hold their last values.
- R3: The opcode encodings are ADD=0, ADC=1, SUB=2, SBB=3, CMP=4, INC=5, DEC=6, AND=7, OR=8, XOR=9, STC=10, CLC=11 and CMC=12. ADC adds bit 0 of flags_i into the sum, and SBB subtracts it from the difference. Carry, at bit 0 of flags_o, is the carry out of the top bit for additions and the borrow for subtractions.
- R4: Auxiliary carry, at bit 4 of flags_o, is the carry out of bit 3 for additions and the borrow into bit 3 for subtractions. Logical operations set it to 0.
- R5: Parity, at bit 2 of flags_o, is 1 exactly when result bits 7:0 hold an even number of ones, at both widths.
- R6: Zero, at bit 6, is 1 when the result within the selected width is all zeros. Sign, at bit 7, is the top bit of the result within the selected width.
- R7: Overflow, at bit 11, is 1 when the signed result of an add or subtract falls outside -128..127 in byte mode or outside -32768..32767 in word mode.
- R8: CMP sets every flag exactly as SUB does on the same operands and presents the difference on result_o, but result_we_o stays 0. It sets carry=1 when a_i is below b_i unsigned, and sets zero=1 with carry=0 when the operands are equal.
- R9: INC and DEC add or subtract 1 from a_i. They update all arithmetic flags except carry, which is copied from flags_i.
- R10: AND, OR and XOR clear carry and overflow and update parity, zero and sign.
- R11: STC sets carry to 1, CLC clears it and CMC inverts it. For these codes and for the unused codes 13 to 15, all other flags_o bits equal flags_i, result_o is 0 and result_we_o is 0.
- R12: With byte_i high, only a_i[7:0] and b_i[7:0] are used, result_o[15:8] is 0, and carry, sign and overflow come from bit 7.
- R13: flags_o bits 1, 3, 5, 8, 9, 10 and 12 to 15 always equal the corresponding bits of flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| byte_i | input | 1 | 1 = byte width, 0 = word width |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flags_i | input | 16 | Current status word |
| valid_o | output | 1 | Result valid |
| result_o | output | 16 | Result value |
| result_we_o | output | 1 | Result belongs in the destination |
| flags_o | output | 16 | Updated status word |

## Verification
On every cycle, the assertions check several properties. Bits outside the six arithmetic flags must pass through unchanged. Parity and zero must agree with the result that was produced. Compare and the carry-flag operations must never raise the write-enable. INC and DEC must leave carry untouched. Logical operations must leave carry, overflow and auxiliary carry at 0. Byte operations must zero the upper result byte. The exact values of carry, auxiliary carry and overflow under borrow-in, width masking and signed boundary operands need a reference model, so only the bench's directed and random scenarios can show them.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_AND = 4'd7,
    OP_OR  = 4'd8,
    OP_XOR = 4'd9,
    OP_STC = 4'd10,
    OP_CLC = 4'd11,
    OP_CMC = 4'd12
  } alu_op_e;

  localparam int unsigned FLAG_W = 16;
  localparam int unsigned CF_BIT = 0;
  localparam int unsigned PF_BIT = 2;
  localparam int unsigned AF_BIT = 4;
  localparam int unsigned ZF_BIT = 6;
  localparam int unsigned SF_BIT = 7;
  localparam int unsigned OF_BIT = 11;

  localparam logic [FLAG_W-1:0] ARITH_MASK =
    FLAG_W'((1 << CF_BIT) | (1 << PF_BIT) | (1 << AF_BIT) |
            (1 << ZF_BIT) | (1 << SF_BIT) | (1 << OF_BIT));

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } arith_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              of_o
);
  localparam int unsigned NIB_W = 4;

  logic [DATA_W-1:0] a_m, b_m, bb;
  logic              c_eff;
  logic [NIB_W:0]    s_nib;
  logic [DATA_W:0]   s_full;
  logic              co;
  logic              a_s, b_s, r_s;

  always_comb begin
    a_m   = byte_i ? {{(DATA_W-BYTE_W){1'b0}}, a_i[BYTE_W-1:0]} : a_i;
    b_m   = byte_i ? {{(DATA_W-BYTE_W){1'b0}}, b_i[BYTE_W-1:0]} : b_i;
    bb    = sub_i ? ~b_m : b_m;
    if (byte_i) bb[DATA_W-1:BYTE_W] = '0;
    // subtract as a + ~b + !borrow
    c_eff = sub_i ? ~cin_i : cin_i;
    s_nib = {1'b0, a_m[NIB_W-1:0]} + {1'b0, bb[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
    s_full = {1'b0, a_m} + {1'b0, bb} + {{DATA_W{1'b0}}, c_eff};
    if (byte_i) begin
      sum_o = {{(DATA_W-BYTE_W){1'b0}}, s_full[BYTE_W-1:0]};
      co    = s_full[BYTE_W];
      a_s   = a_m[BYTE_W-1];
      b_s   = bb[BYTE_W-1];
      r_s   = s_full[BYTE_W-1];
    end else begin
      sum_o = s_full[DATA_W-1:0];
      co    = s_full[DATA_W];
      a_s   = a_m[DATA_W-1];
      b_s   = bb[DATA_W-1];
      r_s   = s_full[DATA_W-1];
    end
    cf_o = co ^ sub_i;
    af_o = s_nib[NIB_W] ^ sub_i;
    of_o = (a_s == b_s) && (r_s != a_s);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sel_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (sel_i)
      2'd0:    raw = a_i & b_i;
      2'd1:    raw = a_i | b_i;
      default: raw = a_i ^ b_i;
    endcase
    res_o = raw;
    if (byte_i) res_o[DATA_W-1:BYTE_W] = '0;
  end
endmodule

// File: rtl/alu_result_flags.sv
module alu_result_flags #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              byte_i,
  output logic              pf_o,
  output logic              zf_o,
  output logic              sf_o
);
  always_comb begin
    pf_o = ~^res_i[BYTE_W-1:0];
    if (byte_i) begin
      zf_o = (res_i[BYTE_W-1:0] == '0);
      sf_o = res_i[BYTE_W-1];
    end else begin
      zf_o = (res_i == '0);
      sf_o = res_i[DATA_W-1];
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_we_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic              is_arith, is_logic, is_incdec, is_sub, use_cin, we_d;
  logic [1:0]        log_sel;
  logic [DATA_W-1:0] b_op, sum, log_res, res_d;
  logic              as_cf, as_af, as_of;
  logic              pf, zf, sf;
  arith_flags_t      af_set;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    is_arith  = 1'b0;
    is_logic  = 1'b0;
    is_incdec = 1'b0;
    is_sub    = 1'b0;
    use_cin   = 1'b0;
    log_sel   = 2'd0;
    unique case (op_i)
      OP_ADD:         is_arith = 1'b1;
      OP_ADC:         begin is_arith = 1'b1; use_cin = 1'b1; end
      OP_SUB, OP_CMP: begin is_arith = 1'b1; is_sub = 1'b1; end
      OP_SBB:         begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; end
      OP_INC:         begin is_arith = 1'b1; is_incdec = 1'b1; end
      OP_DEC:         begin is_arith = 1'b1; is_incdec = 1'b1; is_sub = 1'b1; end
      OP_AND:         begin is_logic = 1'b1; log_sel = 2'd0; end
      OP_OR:          begin is_logic = 1'b1; log_sel = 2'd1; end
      OP_XOR:         begin is_logic = 1'b1; log_sel = 2'd2; end
      default:        ;
    endcase
    b_op = is_incdec ? DATA_W'(1) : b_i;
  end

  alu_addsub #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_op),
    .sub_i  (is_sub),
    .cin_i  (use_cin & flags_i[CF_BIT]),
    .byte_i (byte_i),
    .sum_o  (sum),
    .cf_o   (as_cf),
    .af_o   (as_af),
    .of_o   (as_of)
  );

  alu_logic #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_logic (
    .a_i    (a_i),
    .b_i    (b_i),
    .sel_i  (log_sel),
    .byte_i (byte_i),
    .res_o  (log_res)
  );

  always_comb begin
    if (is_arith)      res_d = sum;
    else if (is_logic) res_d = log_res;
    else               res_d = '0;
  end

  alu_result_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rflags (
    .res_i  (res_d),
    .byte_i (byte_i),
    .pf_o   (pf),
    .zf_o   (zf),
    .sf_o   (sf)
  );

  always_comb begin
    af_set.cf = flags_i[CF_BIT];
    af_set.pf = flags_i[PF_BIT];
    af_set.af = flags_i[AF_BIT];
    af_set.zf = flags_i[ZF_BIT];
    af_set.sf = flags_i[SF_BIT];
    af_set.of = flags_i[OF_BIT];
    if (is_arith) begin
      if (!is_incdec) af_set.cf = as_cf;
      af_set.af = as_af;
      af_set.of = as_of;
      af_set.pf = pf;
      af_set.zf = zf;
      af_set.sf = sf;
    end else if (is_logic) begin
      af_set.cf = 1'b0;
      af_set.af = 1'b0;
      af_set.of = 1'b0;
      af_set.pf = pf;
      af_set.zf = zf;
      af_set.sf = sf;
    end else begin
      unique case (op_i)
        OP_STC:  af_set.cf = 1'b1;
        OP_CLC:  af_set.cf = 1'b0;
        OP_CMC:  af_set.cf = ~flags_i[CF_BIT];
        default: ;
      endcase
    end
    flags_d         = flags_i & ~ARITH_MASK;
    flags_d[CF_BIT] = af_set.cf;
    flags_d[PF_BIT] = af_set.pf;
    flags_d[AF_BIT] = af_set.af;
    flags_d[ZF_BIT] = af_set.zf;
    flags_d[SF_BIT] = af_set.sf;
    flags_d[OF_BIT] = af_set.of;
    we_d = is_logic | (is_arith & (op_i != OP_CMP));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_we_o <= 1'b0;
      result_o    <= '0;
      flags_o     <= '0;
    end else begin
      valid_o     <= valid_i;
      result_we_o <= valid_i & we_d;
      if (valid_i) begin
        result_o <= res_d;
        flags_o  <= flags_d;
      end
    end
  end
endmodule

// File: rtl/flag_alu_sva.sv
module flag_alu_sva
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              byte_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              result_we_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic reset_zero;
  assign reset_zero = !valid_o && !result_we_o && result_o == '0 && flags_o == '0;

  always_comb begin
    if (!rst_ni) a_r1_reset_clear: assert (reset_zero);
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  a_r13_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> ((flags_o & ~ARITH_MASK) == ($past(flags_i) & ~ARITH_MASK)));

  a_r5_parity_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(op_i) <= 4'd9) |->
      (flags_o[PF_BIT] == ~^result_o[BYTE_W-1:0]));

  a_r6_zero_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(op_i) <= 4'd9 && !$past(byte_i)) |->
      (flags_o[ZF_BIT] == (result_o == '0)));

  a_r8_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && ($past(op_i) == 4'(OP_CMP) || $past(op_i) >= 4'(OP_STC))) |->
      !result_we_o);

  a_r9_incdec_keep_cf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && ($past(op_i) == 4'(OP_INC) || $past(op_i) == 4'(OP_DEC))) |->
      (flags_o[CF_BIT] == $past(flags_i[CF_BIT])));

  a_r10_logic_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(op_i) >= 4'(OP_AND) && $past(op_i) <= 4'(OP_XOR)) |->
      (!flags_o[CF_BIT] && !flags_o[OF_BIT] && !flags_o[AF_BIT]));

  a_r12_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(byte_i)) |-> (result_o[DATA_W-1:BYTE_W] == '0));
endmodule

bind flag_alu flag_alu_sva #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .byte_i      (byte_i),
  .flags_i     (flags_i),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .result_we_o (result_we_o),
  .flags_o     (flags_o)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic        byt = 1'b0;
  logic [15:0] a = '0, b = '0, fin = '0;
  logic        valid_o, we_o;
  logic [15:0] res_o, flags_o;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  flag_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .byte_i(byt),
    .a_i(a), .b_i(b), .flags_i(fin), .valid_o(valid_o), .result_o(res_o),
    .result_we_o(we_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sx(input int v, input bit bm);
    if (bm) return (v >= 128) ? v - 256 : v;
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  // returns {we, result[15:0], flags[15:0]}
  function automatic logic [32:0] model(input logic [3:0] o, input logic [15:0] ai,
                                        input logic [15:0] bi, input bit bm,
                                        input logic [15:0] fi);
    int w = bm ? 8 : 16;
    int mask = (1 << w) - 1;
    int av = int'(ai) & mask;
    int bv = int'(bi) & mask;
    int c = 0, full = 0, sr = 0, r = 0;
    int maxp = bm ? 127 : 32767;
    bit sub = 0, arith = 0, lg = 0, keep_cf = 0, we = 0;
    logic [15:0] f = fi;
    case (o)
      4'd0: arith = 1;
      4'd1: begin arith = 1; c = int'(fi[0]); end
      4'd2, 4'd4: begin arith = 1; sub = 1; end
      4'd3: begin arith = 1; sub = 1; c = int'(fi[0]); end
      4'd5: begin arith = 1; bv = 1; keep_cf = 1; end
      4'd6: begin arith = 1; sub = 1; bv = 1; keep_cf = 1; end
      4'd7, 4'd8, 4'd9: lg = 1;
      4'd10: f[0] = 1'b1;
      4'd11: f[0] = 1'b0;
      4'd12: f[0] = ~fi[0];
      default: ;
    endcase
    if (arith) begin
      if (!sub) begin
        full = av + bv + c;
        if (!keep_cf) f[0] = ((full >> w) & 1) != 0;
        f[4] = ((av & 15) + (bv & 15) + c) > 15;
        sr = sx(av, bm) + sx(bv, bm) + c;
      end else begin
        full = av - bv - c;
        if (!keep_cf) f[0] = full < 0;
        f[4] = ((av & 15) - (bv & 15) - c) < 0;
        sr = sx(av, bm) - sx(bv, bm) - c;
      end
      f[11] = (sr > maxp) || (sr < -maxp - 1);
      r = full & mask;
      we = (o != 4'd4);
    end else if (lg) begin
      r = (o == 4'd7) ? (av & bv) : (o == 4'd8) ? (av | bv) : (av ^ bv);
      f[0] = 0; f[4] = 0; f[11] = 0;
      we = 1;
    end
    if (arith || lg) begin
      f[2] = ~^r[7:0];
      f[6] = (r == 0);
      f[7] = ((r >> (w - 1)) & 1) != 0;
    end
    return {we, 16'(r), f};
  endfunction

  task automatic run(input logic [3:0] o, input logic [15:0] ai, input logic [15:0] bi,
                     input bit bm, input logic [15:0] fi, input string req);
    logic [32:0] e;
    e = model(o, ai, bi, bm, fi);
    @(negedge clk);
    op = o; a = ai; b = bi; byt = bm; fin = fi; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk("R2", {req, " valid_o"}, int'(valid_o), 1);
    chk(bm ? "R12" : "R3", {req, " result"}, int'(res_o), int'(e[31:16]));
    chk((o == 4'd4 || o >= 4'd10) ? "R8" : "R3", {req, " we"}, int'(we_o), int'(e[32]));
    chk((o == 4'd5 || o == 4'd6) ? "R9" : (o >= 4'd10) ? "R11" : "R3", {req, " CF"},
        int'(flags_o[0]), int'(e[0]));
    chk("R4", {req, " AF"}, int'(flags_o[4]), int'(e[4]));
    chk("R5", {req, " PF"}, int'(flags_o[2]), int'(e[2]));
    chk("R6", {req, " ZF/SF"}, int'(flags_o[7:6]), int'(e[7:6]));
    chk((o >= 4'd7 && o <= 4'd9) ? "R10" : "R7", {req, " OF"}, int'(flags_o[11]), int'(e[11]));
    chk("R13", {req, " other bits"}, int'(flags_o & 16'hF72A), int'(e[15:0] & 16'hF72A));
  endtask

  initial begin
    logic [15:0] held_r, held_f;
    #1;
    chk("R1", "reset valid_o", int'(valid_o), 0);
    chk("R1", "reset result", int'(res_o), 0);
    chk("R1", "reset flags", int'(flags_o), 0);
    chk("R1", "reset we", int'(we_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    run(4'd0, 16'h007F, 16'h0001, 1'b1, 16'h0000, "R7 byte 7F+1");
    run(4'd0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, "R3 word wrap");
    run(4'd1, 16'h00FF, 16'h0000, 1'b1, 16'h0001, "R3 adc carry in");
    run(4'd3, 16'h0000, 16'h0000, 1'b0, 16'h0001, "R3 sbb borrow");
    run(4'd2, 16'h8000, 16'h0001, 1'b0, 16'h0000, "R7 word 8000-1");
    run(4'd2, 16'h0010, 16'h0001, 1'b0, 16'h0000, "R4 nibble borrow");
    run(4'd4, 16'h1234, 16'h1234, 1'b0, 16'h0001, "R8 cmp equal");
    run(4'd4, 16'h0003, 16'h0009, 1'b0, 16'h0000, "R8 cmp below");
    run(4'd5, 16'hFFFF, 16'h0000, 1'b0, 16'h0001, "R9 inc wrap keep cf");
    run(4'd6, 16'h0000, 16'h0000, 1'b0, 16'h0000, "R9 dec zero keep cf");
    run(4'd6, 16'hAB80, 16'h0000, 1'b1, 16'hFFFF, "R9 byte dec 80");
    run(4'd7, 16'hF0F0, 16'h0FF0, 1'b0, 16'hFFFF, "R10 and");
    run(4'd8, 16'h0100, 16'h0200, 1'b0, 16'h0811, "R5 or upper bits only");
    run(4'd9, 16'hAA55, 16'hAA55, 1'b1, 16'h0801, "R10 xor zero");
    run(4'd0, 16'hFF80, 16'hEE80, 1'b1, 16'h0000, "R12 byte ignores upper");
    run(4'd10, 16'h1234, 16'h5678, 1'b0, 16'h0000, "R11 stc");
    run(4'd11, 16'h1234, 16'h5678, 1'b0, 16'hFFFF, "R11 clc");
    run(4'd12, 16'h0000, 16'h0000, 1'b0, 16'h0A55, "R11 cmc");
    run(4'd14, 16'hFFFF, 16'hFFFF, 1'b0, 16'h5AA5, "R11 unused code");

    run(4'd0, 16'h1111, 16'h2222, 1'b0, 16'h0000, "R2 setup");
    held_r = res_o; held_f = flags_o;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "idle valid_o", int'(valid_o), 0);
    chk("R2", "idle we", int'(we_o), 0);
    chk("R2", "idle result hold", int'(res_o), int'(held_r));
    chk("R2", "idle flags hold", int'(flags_o), int'(held_f));

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra, rb, rf;
      logic [3:0]  ro;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rf = 16'($urandom);
      ro = 4'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: ra = {ra[15:8], 8'h7F};
        1: rb = 16'h8000;
        default: ;
      endcase
      run(ro, ra, rb, 1'($urandom), rf, "R3 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule